// File: doc/BRIEF.md
# Halted-Hart Abstract Command Engine

This block is the command side of a debug controller for one hart. An external debug transport reaches it through an APB slave port with 8-bit word addresses and 32-bit data. Through it the debugger can halt the hart, resume it into M-mode and hold it in reset. While the hart is halted, the debugger can read or write any integer register. The engine does this by feeding instruction words straight into the core's prefetch path. For a register write it injects a CSR read of a reserved scratch CSR, with the target register as destination, and answers that read with the contents of its data word. For a register read it injects a CSR write from the target register and captures the written value into the data word.

After the optional transfer word, the engine can run a two-word program buffer. An implicit `ebreak` always follows it, so the core returns to the halted state once the injected code has run. The core reports that return on `exec_done`. An exception raised by injected code is reported on `dbg_except` instead of reaching the trap handler, and it ends the command. When automatic execution is enabled, every APB access to the data word runs the last command again. Used together with the program buffer, this gives auto-incrementing memory bursts.

Top module: `dbg_cmd_engine`

## Requirements
- R1: The APB slave completes every access with zero wait states and `pslverr` low. Addresses outside the map, and the command register at 0x17, read as zero. The status register at 0x16 reads 0x02000001 after reset: bits [28:24] hold the program buffer size (2), bits [3:0] hold the data word count (1), bit 12 is busy, and bits [10:8] are the error code.
- R2: Bit 31 of the control register at 0x10 drives `hart_halt_req`. The hart-state register at 0x11 reports the halted state in bits 9 and 8 and the running state in bits 11 and 10, with the value 2 in bits [3:0].
- R3: Writing a 1 to control bit 30 with bit 31 clear, while the hart is halted and the engine is idle, raises `hart_resume_req`. The request stays high until `hart_halted` falls. The engine then sets bits 17 and 16 of 0x11, and a new resume request clears them again.
- R4: Control bit 1 drives `hart_reset_req` and reads back from bit 1.
- R5: The command register is at 0x17, and the data word is at 0x04. A command is built from these fields: type [31:24] = 0, size [22:20] = 2, bit 19 = 0, bit 18 = run program buffer, bit 17 = transfer, bit 16 = write, register number [15:0] = 0x1000 + n. With transfer and write set, the engine injects `{CSR, 5'd0, 3'b010, n, 7'h73}` and presents the data word on `xfer_rdata`. Only injection is gated by the halted state.
- R6: With transfer set and write clear, the engine injects `{CSR, n, 3'b001, 5'd0, 7'h73}`. It copies `xfer_wdata` into the data word on each `xfer_wen` during the command.
- R7: Words are injected in this order: the transfer word, then program buffer word 0 (0x20), then word 1 (0x21), then `ebreak` (0x00100073). Words whose control bit is clear are left out, and nothing is injected when neither transfer nor run is set. Busy stays set from the accepting write until `exec_done`.
- R8: The engine rejects a command with error code 2 and does nothing if any of these hold: a nonzero type, bit 23 set, or bit 19 set. With transfer set, it also rejects a size other than 2 or a register number outside 0x1000 to 0x101F.
- R9: A command that arrives while the hart is not halted sets error code 4 and injects nothing.
- R10: While busy, writes to the command register, the automatic-execution register (0x18), the data word or the program buffer are dropped and set error code 1.
- R11: A `dbg_except` pulse during a command ends it at once, clears busy and sets error code 3.
- R12: Writing ones to bits [10:8] of 0x16 clears those error bits. An error code is only recorded while the field is zero. No command starts while the field is nonzero.
- R13: While bit 0 of 0x18 is set, an APB read or write of the data word re-runs the last command. A write lands in the data word first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | 8 | APB word address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always high |
| pslverr | output | 1 | APB error, always low |
| hart_halt_req | output | 1 | Level halt request to the hart |
| hart_resume_req | output | 1 | Resume request, held until the hart runs |
| hart_reset_req | output | 1 | Hart reset request |
| hart_halted | input | 1 | Hart is halted in debug mode |
| inj_word | output | 32 | Instruction word for the prefetch path |
| inj_valid | output | 1 | Injected word is valid |
| inj_ready | input | 1 | Core accepts the injected word |
| xfer_wen | input | 1 | Core writes the intercepted CSR |
| xfer_wdata | input | 32 | Data the core writes |
| xfer_rdata | output | 32 | Data returned for a read of the intercepted CSR |
| dbg_except | input | 1 | Exception raised by injected code |
| exec_done | input | 1 | Core has re-halted after the implicit ebreak |

## Verification
A core model drives the engine. It accepts injected words with a random ready signal, executes the CSR forms against its own register file and re-halts after the `ebreak`. Its log of injected words is compared with the sequence computed from each command's fields. Random commands mix legal register numbers, register number 0, out-of-range numbers, the wrong size, a nonzero type and the reserved bit. This separates the rejection paths from the three legal shapes of sequence: transfer only, transfer then buffer, and buffer only. Directed cases hold the engine busy to test that register writes are locked out. They also raise an exception in the middle of the buffer, run commands against a running hart, and repeat data-word accesses with automatic execution enabled, which shows whether re-runs track reads and writes.

// File: rtl/dbg_cmd_engine.sv
module dbg_cmd_engine #(
  parameter logic [11:0] XFER_CSR = 12'h7b2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [7:0]  paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        pready,
  output logic        pslverr,
  output logic        hart_halt_req,
  output logic        hart_resume_req,
  output logic        hart_reset_req,
  input  logic        hart_halted,
  output logic [31:0] inj_word,
  output logic        inj_valid,
  input  logic        inj_ready,
  input  logic        xfer_wen,
  input  logic [31:0] xfer_wdata,
  output logic [31:0] xfer_rdata,
  input  logic        dbg_except,
  input  logic        exec_done
);

  localparam logic [7:0]  A_DATA0 = 8'h04;
  localparam logic [7:0]  A_CTRL  = 8'h10;
  localparam logic [7:0]  A_STAT  = 8'h11;
  localparam logic [7:0]  A_ACS   = 8'h16;
  localparam logic [7:0]  A_CMD   = 8'h17;
  localparam logic [7:0]  A_AUTO  = 8'h18;
  localparam logic [7:0]  A_PB0   = 8'h20;
  localparam logic [7:0]  A_PB1   = 8'h21;
  localparam logic [31:0] EBREAK  = 32'h0010_0073;
  localparam logic [6:0]  OP_SYS  = 7'h73;

  typedef enum logic [2:0] {S_IDLE, S_XFER, S_PB0, S_PB1, S_EBRK, S_WAIT} state_t;

  state_t      state_q;
  logic [31:0] data0_q, pb0_q, pb1_q, cmd_q;
  logic [2:0]  cmderr_q;
  logic        auto_q, halt_q, hrst_q, resume_q, ack_q;

  logic acc, wr, busy;
  assign acc  = psel & penable;
  assign wr   = acc & pwrite;
  assign busy = state_q != S_IDLE;

  logic cmd_wr, auto_hit, locked_wr, busy_err, go;
  assign cmd_wr    = wr && paddr == A_CMD;
  assign auto_hit  = acc && paddr == A_DATA0 && auto_q;
  assign locked_wr = wr && (paddr == A_CMD || paddr == A_AUTO || paddr == A_DATA0 ||
                            paddr == A_PB0 || paddr == A_PB1);
  assign busy_err  = busy && (locked_wr || auto_hit);
  assign go        = !busy && (cmd_wr || auto_hit);

  logic [31:0] cmd_src;
  logic        c_xfer, c_post, bad, launch;
  assign cmd_src = cmd_wr ? pwdata : cmd_q;
  assign c_xfer  = cmd_src[17];
  assign c_post  = cmd_src[18];
  assign bad     = cmd_src[31:24] != 8'd0 || cmd_src[23] || cmd_src[19] ||
                   (c_xfer && (cmd_src[22:20] != 3'd2 || cmd_src[15:5] != 11'h080));
  assign launch  = go && cmderr_q == 3'd0 && hart_halted && !bad;

  logic [2:0] err_set, err_clr, err_mid;
  always_comb begin
    err_clr = (wr && paddr == A_ACS) ? pwdata[10:8] : 3'd0;
    err_mid = cmderr_q & ~err_clr;
    err_set = 3'd0;
    if (busy_err)                          err_set = 3'd1;
    else if (busy && dbg_except)           err_set = 3'd3;
    else if (go && cmderr_q == 3'd0) begin
      if (!hart_halted)                    err_set = 3'd4;
      else if (bad)                        err_set = 3'd2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmderr_q <= 3'd0;
    else        cmderr_q <= (err_mid == 3'd0 && err_set != 3'd0) ? err_set : err_mid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
    end else if (busy && dbg_except) begin
      state_q <= S_IDLE;
    end else begin
      case (state_q)
        S_IDLE: if (launch) state_q <= c_xfer ? S_XFER : (c_post ? S_PB0 : S_IDLE);
        S_XFER: if (inj_ready) state_q <= cmd_q[18] ? S_PB0 : S_EBRK;
        S_PB0:  if (inj_ready) state_q <= S_PB1;
        S_PB1:  if (inj_ready) state_q <= S_EBRK;
        S_EBRK: if (inj_ready) state_q <= S_WAIT;
        S_WAIT: if (exec_done) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data0_q <= '0; pb0_q <= '0; pb1_q <= '0; cmd_q <= '0; auto_q <= 1'b0;
    end else begin
      if (!busy && wr) begin
        case (paddr)
          A_DATA0: data0_q <= pwdata;
          A_PB0:   pb0_q   <= pwdata;
          A_PB1:   pb1_q   <= pwdata;
          A_CMD:   cmd_q   <= pwdata;
          A_AUTO:  auto_q  <= pwdata[0];
          default: ;
        endcase
      end
      if (busy && xfer_wen) data0_q <= xfer_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0; hrst_q <= 1'b0; resume_q <= 1'b0; ack_q <= 1'b0;
    end else begin
      if (resume_q && !hart_halted) begin
        resume_q <= 1'b0;
        ack_q    <= 1'b1;
      end
      if (wr && paddr == A_CTRL) begin
        halt_q <= pwdata[31];
        hrst_q <= pwdata[1];
        if (pwdata[30] && !pwdata[31] && hart_halted && !busy) begin
          resume_q <= 1'b1;
          ack_q    <= 1'b0;
        end
      end
    end
  end

  assign hart_halt_req   = halt_q;
  assign hart_resume_req = resume_q;
  assign hart_reset_req  = hrst_q;

  always_comb begin
    case (state_q)
      S_XFER:  inj_word = cmd_q[16] ? {XFER_CSR, 5'd0, 3'b010, cmd_q[4:0], OP_SYS}
                                    : {XFER_CSR, cmd_q[4:0], 3'b001, 5'd0, OP_SYS};
      S_PB0:   inj_word = pb0_q;
      S_PB1:   inj_word = pb1_q;
      S_EBRK:  inj_word = EBREAK;
      default: inj_word = 32'd0;
    endcase
  end
  assign inj_valid  = state_q == S_XFER || state_q == S_PB0 || state_q == S_PB1 || state_q == S_EBRK;
  assign xfer_rdata = data0_q;

  always_comb begin
    case (paddr)
      A_DATA0: prdata = data0_q;
      A_CTRL:  prdata = {halt_q, 29'd0, hrst_q, 1'b0};
      A_STAT:  prdata = {14'd0, ack_q, ack_q, 4'd0, !hart_halted, !hart_halted,
                         hart_halted, hart_halted, 4'd0, 4'd2};
      A_ACS:   prdata = {3'd0, 5'd2, 11'd0, busy, 1'b0, cmderr_q, 4'd0, 4'd1};
      A_AUTO:  prdata = {31'd0, auto_q};
      A_PB0:   prdata = pb0_q;
      A_PB1:   prdata = pb1_q;
      default: prdata = 32'd0;
    endcase
  end
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  a_r5_inject_halted: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid |-> hart_halted);
  a_r9_start_halted: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(hart_halted));
  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_wen) |=> data0_q == $past(xfer_wdata));
  a_r10_pb_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr && paddr == A_PB0) |=> $stable(pb0_q) && cmderr_q != 3'd0);
  a_r11_exc_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dbg_except) |=> !busy && cmderr_q != 3'd0);
  a_r3_resume_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hart_resume_req && hart_halted) |=> hart_resume_req);

endmodule

// File: tb/dbg_cmd_engine_tb.sv
`timescale 1ns/1ps
module dbg_cmd_engine_tb;
  localparam logic [11:0] XCSR = 12'h7b2;
  localparam logic [31:0] EBRK = 32'h0010_0073;
  localparam logic [7:0] A_DATA0 = 8'h04, A_CTRL = 8'h10, A_STAT = 8'h11, A_ACS = 8'h16,
                         A_CMD = 8'h17, A_AUTO = 8'h18, A_PB0 = 8'h20, A_PB1 = 8'h21;
  localparam logic [31:0] PBW0 = 32'h0010_8093, PBW1 = 32'h0041_0113;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic psel = 0, penable = 0, pwrite = 0;
  logic [7:0] paddr = 0;
  logic [31:0] pwdata = 0, prdata;
  logic pready, pslverr, halt_req, resume_req, reset_req, halted;
  logic [31:0] inj_word, xfer_wdata, xfer_rdata;
  logic inj_valid, inj_ready, xfer_wen, dbg_except, exec_done;

  dbg_cmd_engine u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .hart_halt_req(halt_req), .hart_resume_req(resume_req), .hart_reset_req(reset_req),
    .hart_halted(halted), .inj_word(inj_word), .inj_valid(inj_valid), .inj_ready(inj_ready),
    .xfer_wen(xfer_wen), .xfer_wdata(xfer_wdata), .xfer_rdata(xfer_rdata),
    .dbg_except(dbg_except), .exec_done(exec_done));

  // core model
  logic [31:0] gpr [0:31];
  logic [31:0] logw [0:2047];
  int log_n, done_cnt;
  int done_delay = 3;
  bit exc_arm = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      halted <= 0; inj_ready <= 0; xfer_wen <= 0; xfer_wdata <= 0;
      dbg_except <= 0; exec_done <= 0; done_cnt <= 0; log_n <= 0;
      for (int i = 0; i < 32; i++) gpr[i] <= (i == 0) ? 32'd0 : 32'h5a00_0000 + i;
    end else begin
      if (!halted && halt_req) halted <= 1;
      else if (halted && resume_req) halted <= 0;
      inj_ready <= ($urandom % 4) != 0;
      xfer_wen <= 0; dbg_except <= 0;
      if (done_cnt != 0) begin done_cnt <= done_cnt - 1; exec_done <= (done_cnt == 1); end
      else exec_done <= 0;
      if (inj_valid && inj_ready) begin
        logw[log_n % 2048] <= inj_word;
        log_n <= log_n + 1;
        if (inj_word == EBRK) done_cnt <= done_delay;
        else if (inj_word[6:0] == 7'h73 && inj_word[31:20] == XCSR && inj_word[14:12] == 3'b010) begin
          if (inj_word[11:7] != 0) gpr[inj_word[11:7]] <= xfer_rdata;
        end else if (inj_word[6:0] == 7'h73 && inj_word[31:20] == XCSR && inj_word[14:12] == 3'b001) begin
          xfer_wen <= 1; xfer_wdata <= gpr[inj_word[19:15]];
        end else if (exc_arm) dbg_except <= 1;
      end
    end
  end

  int n_tests = 0, n_fail = 0;
  bit apb_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin n_fail++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1; if (!pready || pslverr) apb_bad = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); d = prdata; penable = 1; if (!pready || pslverr) apb_bad = 1;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 300; i++) begin apb_rd(A_ACS, v); if (!v[12]) break; end
  endtask

  function automatic logic [31:0] mk(input logic [7:0] ty, input logic [2:0] sz, input bit pinc,
                                     input bit post, input bit xf, input bit w, input logic [15:0] rn);
    return {ty, 1'b0, sz, pinc, post, xf, w, rn};
  endfunction

  function automatic logic [2:0] exp_err(input logic [31:0] c, input bit h);
    if (!h) return 3'd4;
    if (c[31:24] != 0 || c[23] || c[19] || (c[17] && (c[22:20] != 3'd2 || c[15:5] != 11'h080)))
      return 3'd2;
    return 3'd0;
  endfunction

  task automatic check_seq(input int n0, input logic [31:0] c, input string tag);
    logic [31:0] e [0:3];
    int n = 0;
    if (c[17]) begin
      e[n] = c[16] ? {XCSR, 5'd0, 3'b010, c[4:0], 7'h73} : {XCSR, c[4:0], 3'b001, 5'd0, 7'h73};
      n++;
    end
    if (c[18]) begin e[n] = PBW0; n++; e[n] = PBW1; n++; end
    if (c[17] || c[18]) begin e[n] = EBRK; n++; end
    chk(log_n - n0 == n, {tag, " word count"}, log_n - n0, n);
    if (log_n - n0 == n)
      for (int k = 0; k < n; k++) chk(logw[(n0 + k) % 2048] == e[k], {tag, " word"}, logw[(n0 + k) % 2048], e[k]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_tests++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, c, d, g;
    int n0;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_n = 1;
    // R1 reset state and map
    apb_rd(A_ACS, v);  chk(v == 32'h0200_0001, "R1 abstract status reset", v, 32'h0200_0001);
    apb_rd(A_CTRL, v); chk(v == 0, "R2 control reset", v, 0);
    apb_rd(A_STAT, v); chk(v == 32'h0000_0C02, "R2 running status", v, 32'h0000_0C02);
    apb_rd(8'h30, v);  chk(v == 0, "R1 unmapped reads zero", v, 0);
    apb_rd(A_CMD, v);  chk(v == 0, "R1 command reads zero", v, 0);
    chk(halt_req == 0 && reset_req == 0, "R2 outputs after reset", {halt_req, reset_req}, 0);
    // R9 not halted
    n0 = log_n;
    apb_wr(A_CMD, mk(0, 2, 0, 0, 1, 0, 16'h1001));
    apb_rd(A_ACS, v); chk(v[10:8] == 4 && !v[12], "R9 not halted error", v[10:8], 4);
    chk(log_n == n0, "R9 nothing injected", log_n - n0, 0);
    apb_wr(A_ACS, 32'h700);
    apb_rd(A_ACS, v); chk(v[10:8] == 0, "R12 clear error", v[10:8], 0);
    // R2 halt
    apb_wr(A_CTRL, 32'h8000_0000);
    chk(halt_req == 1, "R2 halt request", halt_req, 1);
    repeat (3) @(negedge clk);
    apb_rd(A_STAT, v); chk(v == 32'h0000_0302, "R2 halted status", v, 32'h0000_0302);
    apb_wr(A_PB0, PBW0); apb_wr(A_PB1, PBW1);
    apb_rd(A_PB1, v); chk(v == PBW1, "R7 program buffer readback", v, PBW1);
    // R5 write gpr with postexec
    d = 32'hCAFE_0005; apb_wr(A_DATA0, d);
    c = mk(0, 2, 0, 1, 1, 1, 16'h1005); n0 = log_n;
    apb_wr(A_CMD, c); wait_idle();
    check_seq(n0, c, "R5 write sequence");
    chk(gpr[5] == d, "R5 gpr written", gpr[5], d);
    // R6 read gpr, transfer only
    apb_wr(A_DATA0, 0);
    c = mk(0, 2, 0, 0, 1, 0, 16'h1005); n0 = log_n;
    apb_wr(A_CMD, c); wait_idle();
    check_seq(n0, c, "R6 read sequence");
    apb_rd(A_DATA0, v); chk(v == d, "R6 data0 captured", v, d);
    c = mk(0, 2, 0, 0, 1, 0, 16'h1003);
    apb_wr(A_CMD, c); wait_idle();
    apb_rd(A_DATA0, v); chk(v == 32'h5a00_0003, "R6 read x3", v, 32'h5a00_0003);
    // R7 buffer only, and empty command
    c = mk(0, 3, 0, 1, 0, 0, 16'h0000); n0 = log_n;
    apb_wr(A_CMD, c); wait_idle();
    check_seq(n0, c, "R7 buffer only");
    apb_rd(A_ACS, v); chk(v[10:8] == 0, "R7 size ignored without transfer", v[10:8], 0);
    c = mk(0, 2, 0, 0, 0, 0, 16'h1001); n0 = log_n;
    apb_wr(A_CMD, c); wait_idle();
    chk(log_n == n0, "R7 empty command", log_n - n0, 0);
    // R8 unsupported forms
    foreach (d[i]) if (i < 4) begin
      case (i)
        0: c = mk(0, 3, 0, 0, 1, 0, 16'h1001);
        1: c = mk(0, 2, 0, 0, 1, 0, 16'h1020);
        2: c = mk(1, 2, 0, 0, 1, 0, 16'h1001);
        default: c = mk(0, 2, 1, 0, 1, 0, 16'h1001);
      endcase
      n0 = log_n; apb_wr(A_CMD, c);
      apb_rd(A_ACS, v); chk(v[10:8] == 2, "R8 unsupported", v[10:8], 2);
      chk(log_n == n0, "R8 nothing injected", log_n - n0, 0);
      apb_wr(A_ACS, 32'h700);
    end
    // R12 blocked while error set
    apb_wr(A_CMD, mk(0, 3, 0, 0, 1, 0, 16'h1001));
    n0 = log_n; apb_wr(A_DATA0, 32'h1111_2222);
    apb_wr(A_CMD, mk(0, 2, 0, 0, 1, 1, 16'h1006)); repeat (10) @(negedge clk);
    chk(log_n == n0, "R12 start blocked by error", log_n - n0, 0);
    chk(gpr[6] == 32'h5a00_0006, "R12 gpr untouched", gpr[6], 32'h5a00_0006);
    apb_rd(A_ACS, v); chk(v[10:8] == 2, "R12 error kept", v[10:8], 2);
    apb_wr(A_ACS, 32'h700);
    // R10 busy lockout
    done_delay = 80;
    apb_wr(A_CMD, mk(0, 2, 0, 1, 0, 0, 16'h0));
    apb_wr(A_PB0, 32'hDEAD_BEEF);
    apb_rd(A_ACS, v); chk(v[12] == 1 && v[10:8] == 1, "R10 busy error", v, 32'h0200_1101);
    wait_idle();
    apb_rd(A_PB0, v); chk(v == PBW0, "R10 buffer write dropped", v, PBW0);
    apb_wr(A_ACS, 32'h700); done_delay = 3;
    // R11 exception
    exc_arm = 1;
    apb_wr(A_CMD, mk(0, 2, 0, 1, 0, 0, 16'h0)); wait_idle();
    apb_rd(A_ACS, v); chk(v[10:8] == 3 && !v[12], "R11 exception error", v[10:8], 3);
    exc_arm = 0; apb_wr(A_ACS, 32'h700);
    // R13 automatic execution
    c = mk(0, 2, 0, 0, 1, 1, 16'h1009);
    apb_wr(A_DATA0, 32'hA0A0_0001); apb_wr(A_CMD, c); wait_idle();
    apb_wr(A_AUTO, 1);
    apb_wr(A_DATA0, 32'hA0A0_0002); wait_idle();
    chk(gpr[9] == 32'hA0A0_0002, "R13 rerun on data write", gpr[9], 32'hA0A0_0002);
    apb_wr(A_DATA0, 32'hA0A0_0003); wait_idle();
    chk(gpr[9] == 32'hA0A0_0003, "R13 second rerun", gpr[9], 32'hA0A0_0003);
    c = mk(0, 2, 0, 1, 1, 0, 16'h1009);
    apb_wr(A_CMD, c); wait_idle();
    n0 = log_n; apb_rd(A_DATA0, v); wait_idle();
    chk(v == 32'hA0A0_0003, "R13 data read value", v, 32'hA0A0_0003);
    check_seq(n0, c, "R13 rerun on data read");
    apb_wr(A_AUTO, 0);
    // random commands
    for (int it = 0; it < 40; it++) begin
      logic [15:0] rn;
      logic [2:0] e;
      rn = ($urandom % 8 == 0) ? 16'h1020 : 16'h1000 + 16'($urandom % 32);
      c = mk(($urandom % 8 == 0) ? 8'd1 : 8'd0, ($urandom % 6 == 0) ? 3'd3 : 3'd2,
             ($urandom % 10 == 0), $urandom % 2, $urandom % 2, $urandom % 2, rn);
      e = exp_err(c, 1);
      d = $urandom; apb_wr(A_DATA0, d);
      g = gpr[c[4:0]]; n0 = log_n;
      apb_wr(A_CMD, c); wait_idle();
      apb_rd(A_ACS, v);
      chk(v[10:8] == e, (e != 0) ? "R8 random error code" : "R7 random error code", v[10:8], e);
      if (e == 0) begin
        check_seq(n0, c, "R7 random sequence");
        if (c[17] && c[16])
          chk(gpr[c[4:0]] == ((c[4:0] == 0) ? 0 : d), "R5 random write", gpr[c[4:0]], (c[4:0] == 0) ? 0 : d);
        if (c[17] && !c[16]) begin
          apb_rd(A_DATA0, v); chk(v == g, "R6 random read", v, g);
        end
      end else begin
        chk(log_n == n0, "R8 random nothing injected", log_n - n0, 0);
        apb_wr(A_ACS, 32'h700);
      end
    end
    // R3 resume
    apb_wr(A_CTRL, 32'h0);
    apb_wr(A_CTRL, 32'h4000_0000);
    chk(resume_req == 1, "R3 resume raised", resume_req, 1);
    repeat (4) @(negedge clk);
    chk(resume_req == 0, "R3 resume dropped", resume_req, 0);
    apb_rd(A_STAT, v); chk(v == 32'h0003_0C02, "R3 resume ack", v, 32'h0003_0C02);
    // R4 reset
    apb_wr(A_CTRL, 32'h2);
    chk(reset_req == 1, "R4 reset request", reset_req, 1);
    apb_rd(A_CTRL, v); chk(v == 32'h2, "R4 reset readback", v, 32'h2);
    chk(apb_bad == 0, "R1 zero wait no error", apb_bad, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule